// File: doc/BRIEF.md
# Status-Flag ALU with Byte and Word Widths

This block is the arithmetic and logic unit of a small 16-bit processor core in the classic accumulator style. It takes two operands, an operation code, a width select and the carry bit held by the core. In the same cycle it gives back the result and a write-enable for that result. It also builds a new set of status flags from the result. These flags are stored in a 16-bit flags word at fixed bit positions, and the store happens on the next clock edge when the core asks for it.

Every operation comes in a byte form and a word form. The byte form works on bits 7:0 only, and all flags are taken from that byte. The operations are: add, add with carry, subtract, subtract with borrow, compare, increment, decrement, negate, and, or, xor, not, test, and one-bit shifts and rotates. The rotates can run with or without the carry. The control fields of the flags word (trace, interrupt enable, direction, privilege level, nested task) and its reserved bits are held by this block and never changed. The core reads the flags word back through the `flags` output.

Top module: `flag_alu`

## Requirements
- R1: While reset is low at a clock edge, `flags` loads 16'h0002. After that, bits 1, 3, 5, 8, 9, 10 and 12 to 15 of `flags` keep these reset values forever. The block changes only CF (bit 0), PF (bit 2), AF (bit 4), ZF (bit 6), SF (bit 7) and OF (bit 11).
- R2: ADD (0), ADC (1), SUB (2), SBB (3) and NEG (7) behave as follows. ADC adds `carry_in`, SBB subtracts `carry_in`, and NEG computes 0 minus `op_a`. CF is the carry, or for subtraction the borrow, out of the top bit of the selected width. AF is the carry or borrow out of bit 3. OF is set when the signed result does not fit the selected width.
- R3: ZF, SF and PF are set from the result for the arithmetic, logic and shift operations (codes 0 to 10 and 12 to 15). ZF is set when the result is zero. SF is the top bit of the selected width. PF is set when bits 7:0 of the result hold an even number of ones, in both widths.
- R4: `flags` changes only at a clock edge where `flag_we` is 1. At any other edge it holds its value.
- R5: CMP (4) sets the flags exactly as SUB does, and TEST (12) sets them exactly as AND does. For both, `result_we` is 0.
- R6: INC (5) and DEC (6) add or subtract one and set PF, AF, ZF, SF and OF as ADD and SUB would. CF keeps its stored value.
- R7: AND (8), OR (9), XOR (10) and TEST clear CF, OF and AF. NOT (11) inverts `op_a` and leaves every flag unchanged.
- R8: SHL (13), SHR (14) and SAR (15) move the value by one bit. SHL and SHR shift in a zero; SAR copies the top bit back into itself. CF takes the bit shifted out, OF is set when the top bit of the selected width changes, and AF is cleared.
- R9: ROL (16), ROR (17), RCL (18) and RCR (19) rotate by one bit. RCL and RCR pass the bit through `carry_in`. CF takes the bit moved out, and OF is set when the top bit changes. PF, AF, ZF and SF keep their stored values.
- R10: When `word_sel` is 0, `result[15:8]` is zero, and every flag is taken from bits 7:0.
- R11: Opcodes 20 to 31 give a `result` of 0 and a `result_we` of 0. Even when `flag_we` is 1, they leave `flags` unchanged.
- R12: `result_we` is 1 for every opcode from 0 to 19 except CMP and TEST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| opcode | input | 5 | Operation code (0 to 19 defined) |
| word_sel | input | 1 | 1 selects word width, 0 selects byte width |
| carry_in | input | 1 | Carry used by ADC, SBB, RCL and RCR |
| flag_we | input | 1 | Store the new flags at the next clock edge |
| result | output | 16 | Combinational result |
| result_we | output | 1 | Result is meant to be written back |
| flags | output | 16 | Registered flags word |

## Verification
`result` and `result_we` depend only on the inputs, so they are due in the same cycle as the stimulus. The bench drives the inputs on the falling edge and compares these outputs two nanoseconds later, before the next rising edge. The flags word is due one rising edge after a stimulus with `flag_we` high. The bench compares it one nanosecond after that edge, against a reference flags word that it advances only when it drove `flag_we` high. Because each stimulus is checked before the next one is applied, a stored flag that should have been left alone (by INC, DEC, NOT, a rotate, an unused opcode or `flag_we` low) is seen at the port right away.

// File: rtl/alu_pkg.sv
// Package: shared operation codes, shift kinds and flags-word layout for
// the status-flag ALU. Assumes a 16-bit datapath with an 8-bit byte lane.
package alu_pkg;

    localparam int DW = 16;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_CMP  = 5'd4,
        OP_INC  = 5'd5,
        OP_DEC  = 5'd6,
        OP_NEG  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_NOT  = 5'd11,
        OP_TEST = 5'd12,
        OP_SHL  = 5'd13,
        OP_SHR  = 5'd14,
        OP_SAR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_RCL  = 5'd18,
        OP_RCR  = 5'd19
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_SHL = 3'd0,
        SH_SHR = 3'd1,
        SH_SAR = 3'd2,
        SH_ROL = 3'd3,
        SH_ROR = 3'd4,
        SH_RCL = 3'd5,
        SH_RCR = 3'd6
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_kind_e;

    // Bit positions of the status flags inside the flags word
    localparam int FB_CF = 0;
    localparam int FB_PF = 2;
    localparam int FB_AF = 4;
    localparam int FB_ZF = 6;
    localparam int FB_SF = 7;
    localparam int FB_OF = 11;

    localparam logic [15:0] FLAGS_RST  = 16'h0002;
    localparam logic [15:0] STATUS_MSK = 16'h08D5;

endpackage

// File: rtl/alu_arith.sv
// Module: alu_arith
// Adder/subtractor for byte or word width. For subtraction it forms
// a + ~b + ~cin, so one carry chain serves both directions, and it reports
// the carry or borrow out of the top bit, the carry or borrow out of bit 3,
// and signed overflow. Assumes DW is even; the byte lane is DW/2 bits wide.
module alu_arith #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          word,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] r,
    output logic          co,
    output logic          af,
    output logic          ov
);
    localparam int HB = DW / 2;

    logic [DW-1:0] bx;
    logic          cx;
    logic [DW:0]   sum_w;
    logic [HB:0]   sum_b;
    logic          raw_c;
    logic          a_top;
    logic          bx_top;
    logic          r_top;

    // Invert the second operand and the carry for subtraction
    always_comb begin
        bx = sub ? ~b : b;
        cx = sub ? ~cin : cin;
    end

    // Carry chains for both widths
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cx};
        sum_b = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, cx};
    end

    // Pick the width and derive the carry, auxiliary carry and overflow
    always_comb begin
        r      = word ? sum_w[DW-1:0] : {{HB{1'b0}}, sum_b[HB-1:0]};
        raw_c  = word ? sum_w[DW] : sum_b[HB];
        co     = raw_c ^ sub;
        af     = a[4] ^ b[4] ^ r[4];
        a_top  = word ? a[DW-1]  : a[HB-1];
        bx_top = word ? bx[DW-1] : bx[HB-1];
        r_top  = word ? r[DW-1]  : r[HB-1];
        ov     = ~(a_top ^ bx_top) & (a_top ^ r_top);
    end

endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Bitwise AND, OR, XOR and NOT, with the byte lane selected by width.
// Assumes the caller sets the logic flags; this module only forms the value.
module alu_logic #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]        a,
    input  logic [DW-1:0]        b,
    input  logic                 word,
    input  alu_pkg::logic_kind_e kind,
    output logic [DW-1:0]        r
);
    import alu_pkg::*;
    localparam int HB = DW / 2;

    logic [DW-1:0] full;

    // Bitwise function
    always_comb begin
        unique case (kind)
            LG_AND:  full = a & b;
            LG_OR:   full = a | b;
            LG_XOR:  full = a ^ b;
            default: full = ~a;
        endcase
    end

    // Clear the upper byte in byte mode
    always_comb r = word ? full : {{HB{1'b0}}, full[HB-1:0]};

endmodule

// File: rtl/alu_shift.sv
// Module: alu_shift
// One-bit shifts and rotates at byte or word width. It reports the bit
// moved out as carry, and overflow when the top bit of the width changes.
// Assumes the carry used by the carry rotates arrives on cin.
module alu_shift #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]        a,
    input  logic                 word,
    input  alu_pkg::shift_kind_e kind,
    input  logic                 cin,
    output logic [DW-1:0]        r,
    output logic                 co,
    output logic                 ov
);
    import alu_pkg::*;
    localparam int HB = DW / 2;
    localparam int IW = $clog2(DW);

    logic [DW-1:0] am;
    logic [IW-1:0] top_idx;
    logic          top;
    logic          fill;
    logic          go_left;
    logic [DW-1:0] moved;

    // Operand masked to the width, and the index of the top bit
    always_comb begin
        am      = word ? a : {{HB{1'b0}}, a[HB-1:0]};
        top_idx = word ? IW'(DW - 1) : IW'(HB - 1);
        top     = am[top_idx];
    end

    // Direction and the bit entering the vacated end
    always_comb begin
        unique case (kind)
            SH_SHL:  begin go_left = 1'b1; fill = 1'b0;  end
            SH_SHR:  begin go_left = 1'b0; fill = 1'b0;  end
            SH_SAR:  begin go_left = 1'b0; fill = top;   end
            SH_ROL:  begin go_left = 1'b1; fill = top;   end
            SH_ROR:  begin go_left = 1'b0; fill = am[0]; end
            SH_RCL:  begin go_left = 1'b1; fill = cin;   end
            default: begin go_left = 1'b0; fill = cin;   end
        endcase
    end

    // Move the value by one place and insert the fill bit
    always_comb begin
        if (go_left) begin
            moved    = {am[DW-2:0], fill};
            co       = top;
        end else begin
            moved          = am >> 1;
            moved[top_idx] = fill;
            co             = am[0];
        end
    end

    // Trim to the width and flag a change of the top bit
    always_comb begin
        r  = word ? moved : {{HB{1'b0}}, moved[HB-1:0]};
        ov = r[top_idx] ^ top;
    end

endmodule

// File: rtl/flag_alu.sv
// Module: flag_alu (top)
// Status-flag ALU: decodes the opcode, steers the operands to the adder,
// the logic unit or the shifter, selects the result and computes the next
// status flags. The flags word is a register that loads on flag_we; only
// CF, PF, AF, ZF, SF and OF are written. Assumes opcodes 20..31 are unused.
module flag_alu #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [4:0]    opcode,
    input  logic          word_sel,
    input  logic          carry_in,
    input  logic          flag_we,
    output logic [DW-1:0] result,
    output logic          result_we,
    output logic [15:0]   flags
);
    import alu_pkg::*;
    localparam int HB = DW / 2;

    typedef enum logic [2:0] {
        CL_ARITH, CL_INCDEC, CL_LOGIC, CL_NOT, CL_SHIFT, CL_ROT, CL_NONE
    } op_class_e;

    op_class_e     op_cls;
    logic [DW-1:0] ar_a, ar_b;
    logic          ar_sub, ar_cin;
    logic [DW-1:0] ar_r;
    logic          ar_co, ar_af, ar_ov;
    logic_kind_e   lg_kind;
    logic [DW-1:0] lg_r;
    shift_kind_e   sh_kind;
    logic [DW-1:0] sh_r;
    logic          sh_co, sh_ov;
    logic [15:0]   flags_q;
    logic [15:0]   flags_nxt;
    logic [DW-1:0] res;
    logic          zf_n, sf_n, pf_n;

    // Operation class and operand steering for the adder
    always_comb begin
        op_cls  = CL_NONE;
        ar_a    = op_a;
        ar_b    = op_b;
        ar_sub  = 1'b0;
        ar_cin  = 1'b0;
        lg_kind = LG_AND;
        sh_kind = SH_SHL;
        case (opcode)
            OP_ADD:  op_cls = CL_ARITH;
            OP_ADC:  begin op_cls = CL_ARITH; ar_cin = carry_in; end
            OP_SUB,
            OP_CMP:  begin op_cls = CL_ARITH; ar_sub = 1'b1; end
            OP_SBB:  begin op_cls = CL_ARITH; ar_sub = 1'b1; ar_cin = carry_in; end
            OP_INC:  begin op_cls = CL_INCDEC; ar_b = DW'(1); end
            OP_DEC:  begin op_cls = CL_INCDEC; ar_b = DW'(1); ar_sub = 1'b1; end
            OP_NEG:  begin op_cls = CL_ARITH; ar_a = '0; ar_b = op_a; ar_sub = 1'b1; end
            OP_AND,
            OP_TEST: begin op_cls = CL_LOGIC; lg_kind = LG_AND; end
            OP_OR:   begin op_cls = CL_LOGIC; lg_kind = LG_OR; end
            OP_XOR:  begin op_cls = CL_LOGIC; lg_kind = LG_XOR; end
            OP_NOT:  begin op_cls = CL_NOT;   lg_kind = LG_NOT; end
            OP_SHL:  begin op_cls = CL_SHIFT; sh_kind = SH_SHL; end
            OP_SHR:  begin op_cls = CL_SHIFT; sh_kind = SH_SHR; end
            OP_SAR:  begin op_cls = CL_SHIFT; sh_kind = SH_SAR; end
            OP_ROL:  begin op_cls = CL_ROT;   sh_kind = SH_ROL; end
            OP_ROR:  begin op_cls = CL_ROT;   sh_kind = SH_ROR; end
            OP_RCL:  begin op_cls = CL_ROT;   sh_kind = SH_RCL; end
            OP_RCR:  begin op_cls = CL_ROT;   sh_kind = SH_RCR; end
            default: op_cls = CL_NONE;
        endcase
    end

    alu_arith #(.DW(DW)) u_arith (
        .a    (ar_a),
        .b    (ar_b),
        .word (word_sel),
        .sub  (ar_sub),
        .cin  (ar_cin),
        .r    (ar_r),
        .co   (ar_co),
        .af   (ar_af),
        .ov   (ar_ov)
    );

    alu_logic #(.DW(DW)) u_logic (
        .a    (op_a),
        .b    (op_b),
        .word (word_sel),
        .kind (lg_kind),
        .r    (lg_r)
    );

    alu_shift #(.DW(DW)) u_shift (
        .a    (op_a),
        .word (word_sel),
        .kind (sh_kind),
        .cin  (carry_in),
        .r    (sh_r),
        .co   (sh_co),
        .ov   (sh_ov)
    );

    // Result selection and write-back enable
    always_comb begin
        unique case (op_cls)
            CL_ARITH, CL_INCDEC: res = ar_r;
            CL_LOGIC, CL_NOT:    res = lg_r;
            CL_SHIFT, CL_ROT:    res = sh_r;
            default:             res = '0;
        endcase
        result    = res;
        result_we = (op_cls != CL_NONE) && (opcode != OP_CMP) && (opcode != OP_TEST);
    end

    // Zero, sign and low-byte parity of the selected result
    always_comb begin
        zf_n = word_sel ? (res == '0) : (res[HB-1:0] == '0);
        sf_n = word_sel ? res[DW-1] : res[HB-1];
        pf_n = ~^res[7:0];
    end

    // Next flags word for each operation class
    always_comb begin
        flags_nxt = flags_q;
        unique case (op_cls)
            CL_ARITH: begin
                flags_nxt[FB_CF] = ar_co;
                flags_nxt[FB_AF] = ar_af;
                flags_nxt[FB_OF] = ar_ov;
                flags_nxt[FB_ZF] = zf_n;
                flags_nxt[FB_SF] = sf_n;
                flags_nxt[FB_PF] = pf_n;
            end
            CL_INCDEC: begin
                flags_nxt[FB_AF] = ar_af;
                flags_nxt[FB_OF] = ar_ov;
                flags_nxt[FB_ZF] = zf_n;
                flags_nxt[FB_SF] = sf_n;
                flags_nxt[FB_PF] = pf_n;
            end
            CL_LOGIC: begin
                flags_nxt[FB_CF] = 1'b0;
                flags_nxt[FB_AF] = 1'b0;
                flags_nxt[FB_OF] = 1'b0;
                flags_nxt[FB_ZF] = zf_n;
                flags_nxt[FB_SF] = sf_n;
                flags_nxt[FB_PF] = pf_n;
            end
            CL_SHIFT: begin
                flags_nxt[FB_CF] = sh_co;
                flags_nxt[FB_AF] = 1'b0;
                flags_nxt[FB_OF] = sh_ov;
                flags_nxt[FB_ZF] = zf_n;
                flags_nxt[FB_SF] = sf_n;
                flags_nxt[FB_PF] = pf_n;
            end
            CL_ROT: begin
                flags_nxt[FB_CF] = sh_co;
                flags_nxt[FB_OF] = sh_ov;
            end
            default: flags_nxt = flags_q;
        endcase
    end

    // Flags register: reset value, then status bits only on flag_we
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_RST;
        end else if (flag_we) begin
            flags_q <= (flags_q & ~STATUS_MSK) | (flags_nxt & STATUS_MSK);
        end
    end

    assign flags = flags_q;

    // R1
    ctrl_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~STATUS_MSK) == (FLAGS_RST & ~STATUS_MSK));

    // R4
    flags_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));

    // R6
    incdec_cf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (opcode == OP_INC || opcode == OP_DEC))
        |=> flags_q[FB_CF] == $past(flags_q[FB_CF]));

    // R3
    zero_flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && opcode <= OP_SAR && opcode != OP_NOT)
        |=> flags_q[FB_ZF] == ($past(result) == '0));

    // R10
    byte_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sel |-> result[DW-1:HB] == '0);

    // R11
    unused_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode > OP_RCR) |=> flags_q == $past(flags_q));

endmodule

// File: tb/flag_alu_bench.sv
// Bench for flag_alu: a behavioural reference built from integer arithmetic
// is compared each cycle, the result mid-cycle and the flags after the edge.
module flag_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [4:0]  opcode = '0;
    logic        word_sel = 1'b1, carry_in = 1'b0, flag_we = 1'b0;
    logic [15:0] result;
    logic        result_we;
    logic [15:0] flags;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_flags;
    logic [15:0] e_res;
    logic        e_we;
    logic [15:0] e_flags;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    flag_alu u_flag_alu (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .word_sel(word_sel), .carry_in(carry_in), .flag_we(flag_we),
        .result(result), .result_we(result_we), .flags(flags)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input bit w);
        if (!w) return "R10";
        if (op == 4 || op == 12) return "R5";
        if (op == 5 || op == 6) return "R6";
        if (op >= 8 && op <= 11) return "R7";
        if (op >= 13 && op <= 15) return "R8";
        if (op >= 16 && op <= 19) return "R9";
        if (op > 19) return "R11";
        return "R2";
    endfunction

    function automatic int sx(input int v, input int half);
        return (v >= half) ? v - 2 * half : v;
    endfunction

    // Reference: compute expected result, write-enable and flags
    task automatic model(input int op, input int a, input int b, input bit w, input bit c);
        int mask, half, ua, ub, full, s, r;
        bit cf, af, of, setz, keepcf, rot, touch;
        mask = w ? 'hFFFF : 'hFF;
        half = w ? 'h8000 : 'h80;
        ua = a & mask; ub = b & mask;
        cf = m_flags[0]; af = m_flags[4]; of = m_flags[11];
        r = 0; setz = 1'b1; keepcf = 1'b0; rot = 1'b0; touch = 1'b1;
        case (op)
            0, 1, 5: begin
                if (op == 5) begin ub = 1; keepcf = 1'b1; end
                full = ua + ub + ((op == 1) ? int'(c) : 0);
                s = sx(ua, half) + sx(ub, half) + ((op == 1) ? int'(c) : 0);
                r = full & mask; cf = full > mask;
                af = ((ua ^ ub ^ r) >> 4) & 1;
                of = (s >= half) || (s < -half);
            end
            2, 3, 4, 6, 7: begin
                if (op == 6) begin ub = 1; keepcf = 1'b1; end
                if (op == 7) begin ub = ua; ua = 0; end
                full = ua - ub - ((op == 3) ? int'(c) : 0);
                s = sx(ua, half) - sx(ub, half) - ((op == 3) ? int'(c) : 0);
                r = full & mask; cf = full < 0;
                af = ((ua ^ ub ^ r) >> 4) & 1;
                of = (s >= half) || (s < -half);
            end
            8, 12: begin r = ua & ub; cf = 0; af = 0; of = 0; end
            9:     begin r = ua | ub; cf = 0; af = 0; of = 0; end
            10:    begin r = ua ^ ub; cf = 0; af = 0; of = 0; end
            11:    begin r = (~ua) & mask; touch = 1'b0; end
            13: begin r = (ua << 1) & mask; cf = (ua & half) != 0; af = 0; end
            14: begin r = ua >> 1; cf = ua & 1; af = 0; end
            15: begin r = (ua >> 1) | (ua & half); cf = ua & 1; af = 0; end
            16: begin r = ((ua << 1) & mask) | ((ua & half) ? 1 : 0); cf = (ua & half) != 0; rot = 1; end
            17: begin r = (ua >> 1) | ((ua & 1) ? half : 0); cf = ua & 1; rot = 1; end
            18: begin r = ((ua << 1) & mask) | int'(c); cf = (ua & half) != 0; rot = 1; end
            19: begin r = (ua >> 1) | (c ? half : 0); cf = ua & 1; rot = 1; end
            default: begin r = 0; touch = 1'b0; end
        endcase
        if (op >= 13 && op <= 19) of = ((r ^ ua) & half) != 0;
        e_res = 16'(r);
        e_we  = (op <= 19) && op != 4 && op != 12;
        e_flags = m_flags;
        if (touch) begin
            if (!keepcf) e_flags[0] = cf;
            e_flags[11] = of;
            if (!rot) begin
                e_flags[4] = af;
                e_flags[6] = (r == 0);
                e_flags[7] = (r & half) != 0;
                e_flags[2] = ~^r[7:0];
            end
        end
    endtask

    task automatic step(input int op, input int a, input int b, input bit w, input bit c, input bit we);
        string t;
        @(negedge clk);
        opcode = 5'(op); op_a = 16'(a); op_b = 16'(b);
        word_sel = w; carry_in = c; flag_we = we;
        model(op, a, b, w, c);
        t = tag_of(op, w);
        #2;
        chk(t, "result", result, e_res);
        chk((op == 4 || op == 12) ? "R5" : "R12", "result_we", result_we, e_we);
        @(posedge clk);
        #1;
        if (we) m_flags = e_flags;
        chk(we ? "R3" : "R4", "flags zf/sf/pf", flags & 16'h00C4, m_flags & 16'h00C4);
        chk(we ? t : "R4", "flags cf/af/of", flags & 16'h0811, m_flags & 16'h0811);
        chk("R1", "flags ctrl", flags & 16'hF72A, 16'h0002);
    endtask

    initial begin
        m_flags = 16'h0002;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset flags", flags, 16'h0002);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 word overflow into sign, byte carry to zero, borrows
        step(0, 'h7FFF, 'h0001, 1, 0, 1);
        step(0, 'h00FF, 'h0001, 0, 0, 1);
        step(1, 'h1234, 'h0001, 1, 1, 1);
        step(2, 'h0000, 'h0001, 1, 0, 1);
        step(3, 'h0080, 'h0000, 0, 1, 1);
        step(7, 'h0080, 0, 0, 0, 1);
        step(7, 'h0000, 0, 1, 0, 1);
        // R6 carry survives increment and decrement
        step(0, 'hFFFF, 'h0001, 1, 0, 1);
        step(5, 'h7FFF, 0, 1, 0, 1);
        step(6, 'h0000, 0, 0, 0, 1);
        // R5 compare and test
        step(4, 'h0005, 'h0007, 1, 0, 1);
        step(12, 'hF0F0, 'h0F0F, 1, 0, 1);
        // R7 logic and not
        step(10, 'hAAAA, 'h5555, 1, 0, 1);
        step(0, 'h8000, 'h8000, 1, 0, 1);
        step(11, 'h00F0, 0, 0, 0, 1);
        // R8 and R9 shifts and rotates
        step(13, 'h4000, 0, 1, 0, 1);
        step(15, 'h0081, 0, 0, 0, 1);
        step(18, 'h0080, 0, 0, 1, 1);
        step(19, 'h0001, 0, 1, 1, 1);
        // R11 unused codes, R4 write disabled
        step(25, 'hFFFF, 'hFFFF, 1, 1, 1);
        step(2, 'h0000, 'h0001, 1, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 21), $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule